// File: doc/BRIEF.md
# Display Controller Status and Interrupt Register Block

This block sits beside a graphics display controller and gathers its event and status reporting into three bus-visible registers. Five event sources (signal, finish, horizontal sync, vertical sync, rectangle-write-end) each set a sticky pending bit. Each pending bit is gated by its own mask bit, and the results are ORed into a single interrupt line. Software acknowledges an event by writing 1 to that event's bit position in the control/status register. A read of the same register returns live status: the pending events, the current display field, the FIFO fill state, and fixed revision and ID codes.

The control/status register has two personalities. On a write, bits 8 and 9 are commands that emit one-cycle flush and soft-reset pulses to the rest of the controller. On a read, those two bits are always zero. A soft reset also returns the interrupt mask to all ones, which masks every event. A separate register pair holds a 32-bit signal ID and a 32-bit label ID for the drawing engine to consult.

The register port has a write strobe, a word address and write data. Read data is combinational from the address.

Top module: `disp_stat_regs`

## Requirements
- R1: A one-cycle pulse on `evt_i[k]` sets pending bit k. After the next clock edge, bit k of the control/status register (offset 0x1000) reads 1. The bit order is 0 signal, 1 finish, 2 horizontal sync, 3 vertical sync, 4 rectangle-write-end.
- R2: A write to offset 0x1000 with 1 in bit k (k in 0..4) clears pending bit k. A 0 in that bit leaves pending bit k unchanged.
- R3: If an event pulse and a write-1 acknowledge for the same bit fall in the same cycle, the bit stays pending.
- R4: A write to offset 0x1000 with bit 8 set makes `flush_o` high for exactly the one cycle after the write. A write with bit 9 set does the same for `soft_rst_o`. Bits 8 and 9 of the control/status register always read 0.
- R5: A soft-reset command sets all five mask bits to 1 on the same edge that raises `soft_rst_o`. Pending bits are not changed by it.
- R6: Bit 13 of the control/status register is the display field (0 even, 1 odd). It reads 0 after reset and toggles on each vertical sync event.
- R7: Bits 15:14 of the control/status register report FIFO state: 01 when `fifo_empty_i` is high (this takes precedence), otherwise 10 when `fifo_afull_i` is high, otherwise 00. The code 11 is never produced.
- R8: Bits 23:16 of the control/status register read 0x1B and bits 31:24 read 0x55. All other unassigned bits read 0.
- R9: A write to the mask register (offset 0x1010) stores only bits 12:8 (mask for events 0..4 in order). On a read, bits 14:13 return 1 and all other bits return 0. The mask resets to 0x1F.
- R10: `irq_o` is high exactly when some pending bit k has mask bit k equal to 0. It reflects a pending or mask change on the same edge that changes the register.
- R11: The signal ID register (offset 0x1080) and the label ID register (offset 0x1084) store all 32 written bits and read them back.
- R12: After reset, all pending bits and both ID registers are 0, the mask is 0x1F, and `flush_o`, `soft_rst_o` and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 13 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| evt_i | input | 5 | Event pulses: signal, finish, hsync, vsync, rect-write-end |
| fifo_empty_i | input | 1 | FIFO empty status |
| fifo_afull_i | input | 1 | FIFO almost-full status |
| irq_o | output | 1 | Interrupt: an unmasked event is pending |
| flush_o | output | 1 | One-cycle flush command pulse |
| soft_rst_o | output | 1 | One-cycle soft-reset command pulse |

## Verification
A pending bit that is stuck, lost or wrongly cleared shows on the next read of offset 0x1000 and on `irq_o` in the cycle after the event or write that should have changed it. A wrong mask bit shows as an `irq_o` mismatch in that same cycle. The bench therefore compares both ports after every step of exhaustive sweeps over pending, acknowledge and mask patterns. A field bit that misses a toggle, or a command pulse that is late or stretched, is visible in the first or second cycle after the triggering write or vertical sync.

// File: rtl/disp_stat_pkg.sv
package disp_stat_pkg;
  localparam int ADDR_W = 13;
  localparam int DATA_W = 32;
  localparam int N_EVT  = 5;

  localparam logic [ADDR_W-1:0] CSR_OFS = 13'h1000;
  localparam logic [ADDR_W-1:0] MSK_OFS = 13'h1010;
  localparam logic [ADDR_W-1:0] SIG_OFS = 13'h1080;
  localparam logic [ADDR_W-1:0] LBL_OFS = 13'h1084;

  localparam int EVT_VSYNC   = 3;
  localparam int FLUSH_BIT   = 8;
  localparam int SRST_BIT    = 9;
  localparam int FIELD_BIT   = 13;
  localparam int FIFO_LSB    = 14;
  localparam int REV_LSB     = 16;
  localparam int ID_LSB      = 24;
  localparam int MSK_LSB     = 8;
  localparam int MSK_FIX_LSB = MSK_LSB + N_EVT;

  typedef enum logic [1:0] {
    FIFO_MID   = 2'b00,
    FIFO_EMPTY = 2'b01,
    FIFO_AFULL = 2'b10,
    FIFO_RSVD  = 2'b11
  } fifo_stat_e;
endpackage

// File: rtl/disp_evt_bank.sv
module disp_evt_bank #(
  parameter int N_EVT = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] evt_i,
  input  logic [N_EVT-1:0] ack_i,
  output logic [N_EVT-1:0] pend_o
);
  logic [N_EVT-1:0] pend_q;

  for (genvar k = 0; k < N_EVT; k++) begin : g_pend
    // new event beats a same-cycle acknowledge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_q[k] <= 1'b0;
      else if (evt_i[k]) pend_q[k] <= 1'b1;
      else if (ack_i[k]) pend_q[k] <= 1'b0;
    end

    // R1 R3
    evt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[k] |=> pend_o[k]);
    // R2
    ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[k] && !evt_i[k]) |=> !pend_o[k]);
    // R2
    pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ack_i[k] && !evt_i[k]) |=> $stable(pend_o[k]));
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/disp_irq_mask.sv
module disp_irq_mask #(
  parameter int N_EVT = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [N_EVT-1:0] wdata_i,
  input  logic             srst_i,
  input  logic [N_EVT-1:0] pend_i,
  output logic [N_EVT-1:0] mask_o,
  output logic             irq_o
);
  logic [N_EVT-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mask_q <= '1;
    else if (srst_i) mask_q <= '1;
    else if (wr_i)   mask_q <= wdata_i;
  end

  assign mask_o = mask_q;
  assign irq_o  = |(pend_i & ~mask_q);

  // R9
  mask_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !srst_i) |=> $stable(mask_o));
  // R5
  mask_srst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (mask_o == '1));
endmodule

// File: rtl/disp_csr_cmd.sv
module disp_csr_cmd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic flush_bit_i,
  input  logic srst_bit_i,
  input  logic vsync_i,
  output logic flush_o,
  output logic srst_o,
  output logic field_o
);
  logic flush_q, srst_q, field_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_q <= 1'b0;
      srst_q  <= 1'b0;
      field_q <= 1'b0;
    end else begin
      flush_q <= wr_i & flush_bit_i;
      srst_q  <= wr_i & srst_bit_i;
      if (vsync_i) field_q <= ~field_q;
    end
  end

  assign flush_o = flush_q;
  assign srst_o  = srst_q;
  assign field_o = field_q;

  // R6
  field_tgl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_i |=> (field_o != $past(field_o)));
  // R6
  field_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_i |=> $stable(field_o));
  // R4
  flush_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> !flush_o && !srst_o);
endmodule

// File: rtl/disp_stat_regs.sv
module disp_stat_regs
  import disp_stat_pkg::*;
#(
  parameter logic [7:0] REV_CODE = 8'h1B,
  parameter logic [7:0] ID_CODE  = 8'h55
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic              fifo_empty_i,
  input  logic              fifo_afull_i,
  output logic              irq_o,
  output logic              flush_o,
  output logic              soft_rst_o
);
  logic csr_wr, msk_wr, sig_wr, lbl_wr, srst_cmd, field;
  logic [N_EVT-1:0]  pend, mask, ack;
  logic [DATA_W-1:0] sig_q, lbl_q;
  fifo_stat_e        fifo_st;

  assign csr_wr   = wr_en_i && (addr_i == CSR_OFS);
  assign msk_wr   = wr_en_i && (addr_i == MSK_OFS);
  assign sig_wr   = wr_en_i && (addr_i == SIG_OFS);
  assign lbl_wr   = wr_en_i && (addr_i == LBL_OFS);
  assign ack      = csr_wr ? wdata_i[N_EVT-1:0] : '0;
  assign srst_cmd = csr_wr && wdata_i[SRST_BIT];

  disp_evt_bank #(.N_EVT(N_EVT)) u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .ack_i  (ack),
    .pend_o (pend)
  );

  disp_irq_mask #(.N_EVT(N_EVT)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (msk_wr),
    .wdata_i (wdata_i[MSK_LSB +: N_EVT]),
    .srst_i  (srst_cmd),
    .pend_i  (pend),
    .mask_o  (mask),
    .irq_o   (irq_o)
  );

  disp_csr_cmd u_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (csr_wr),
    .flush_bit_i (wdata_i[FLUSH_BIT]),
    .srst_bit_i  (wdata_i[SRST_BIT]),
    .vsync_i     (evt_i[EVT_VSYNC]),
    .flush_o     (flush_o),
    .srst_o      (soft_rst_o),
    .field_o     (field)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sig_q <= '0;
      lbl_q <= '0;
    end else begin
      if (sig_wr) sig_q <= wdata_i;
      if (lbl_wr) lbl_q <= wdata_i;
    end
  end

  always_comb begin
    if (fifo_empty_i)      fifo_st = FIFO_EMPTY;
    else if (fifo_afull_i) fifo_st = FIFO_AFULL;
    else                   fifo_st = FIFO_MID;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      CSR_OFS: begin
        rdata_o[N_EVT-1:0]     = pend;
        rdata_o[FIELD_BIT]     = field;
        rdata_o[FIFO_LSB +: 2] = fifo_st;
        rdata_o[REV_LSB +: 8]  = REV_CODE;
        rdata_o[ID_LSB +: 8]   = ID_CODE;
      end
      MSK_OFS: begin
        rdata_o[MSK_LSB +: N_EVT]  = mask;
        rdata_o[MSK_FIX_LSB +: 2]  = 2'b11;
      end
      SIG_OFS: rdata_o = sig_q;
      LBL_OFS: rdata_o = lbl_q;
      default: rdata_o = '0;
    endcase
  end

  // R5
  srst_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> (mask == '1));
  // R7
  fifo_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_st != FIFO_RSVD);
  // R10
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend == '0) |-> !irq_o);
endmodule

// File: tb/disp_stat_regs_tb_top.sv
module disp_stat_regs_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [12:0] addr_i = 13'h1000;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [4:0]  evt_i = '0;
  logic        fifo_empty_i = 1'b1;
  logic        fifo_afull_i = 1'b0;
  logic        irq_o, flush_o, soft_rst_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [4:0] m_pend = '0;
  logic [4:0] m_mask = 5'h1F;
  logic       m_field = 1'b0;
  logic [1:0] m_fifo = 2'b01;

  always #5 clk_i = ~clk_i;

  disp_stat_regs dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_csr();
    return {8'h55, 8'h1B, m_fifo, m_field, 8'h00, m_pend};
  endfunction

  function automatic logic [31:0] exp_msk();
    return {17'h0, 2'b11, m_mask, 8'h00};
  endfunction

  task automatic rd(input logic [12:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  // drive at negedge, one posedge, return at next negedge
  task automatic cyc(input logic we, input logic [12:0] a, input logic [31:0] d, input logic [4:0] e);
    wr_en_i = we; addr_i = a; wdata_i = d; evt_i = e;
    @(negedge clk_i);
    wr_en_i = 1'b0; evt_i = '0; wdata_i = '0;
    if (e[3]) m_field = ~m_field;
  endtask

  task automatic pulse(input logic [4:0] e);
    cyc(1'b0, 13'h1000, '0, e);
    m_pend = m_pend | e;
  endtask

  task automatic ack(input logic [4:0] a);
    cyc(1'b1, 13'h1000, {27'h0, a}, '0);
    m_pend = m_pend & ~a;
  endtask

  task automatic set_mask(input logic [4:0] m);
    cyc(1'b1, 13'h1010, {19'h0, m, 8'h00}, '0);
    m_mask = m;
  endtask

  task automatic chk_state(input string req);
    logic [31:0] d;
    rd(13'h1000, d);
    chk(req, d, exp_csr());
    chk({req, " irq"}, {31'h0, irq_o}, {31'h0, |(m_pend & ~m_mask)});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R12 reset state, R8 constants, R7 empty after reset
    rd(13'h1000, d); chk("R12 csr", d, 32'h551B_4000);
    rd(13'h1010, d); chk("R12 R9 mask", d, 32'h0000_7F00);
    rd(13'h1080, d); chk("R12 sig", d, 0);
    rd(13'h1084, d); chk("R12 lbl", d, 0);
    chk("R12 outs", {29'h0, irq_o, flush_o, soft_rst_o}, 0);

    // R1 R2: every pending pattern against every acknowledge pattern
    set_mask(5'h00);
    for (int p = 0; p < 32; p++) begin
      for (int a = 0; a < 32; a++) begin
        ack(5'h1F);
        pulse(p[4:0]);
        chk_state("R1 R6 R10");
        ack(a[4:0]);
        chk_state("R2 R10");
      end
    end

    // R3: event and acknowledge in the same cycle
    for (int p = 0; p < 32; p++) begin
      pulse(5'h1F);
      cyc(1'b1, 13'h1000, 32'h1F, p[4:0]);
      m_pend = p[4:0];
      chk_state("R3");
    end

    // R9 R10: every mask against every pending pattern
    for (int m = 0; m < 32; m++) begin
      set_mask(m[4:0]);
      rd(13'h1010, d); chk("R9 mask read", d, exp_msk());
      for (int p = 0; p < 32; p++) begin
        ack(5'h1F);
        chk_state("R10 idle");
        pulse(p[4:0]);
        chk_state("R10");
      end
    end
    // R9: only bits 12:8 stored
    cyc(1'b1, 13'h1010, 32'hFFFF_E0FF, '0);
    m_mask = 5'h00;
    rd(13'h1010, d); chk("R9 stray bits", d, exp_msk());
    cyc(1'b1, 13'h1010, 32'h0000_1500, '0);
    m_mask = 5'h15;
    rd(13'h1010, d); chk("R9 partial", d, exp_msk());

    // R4 flush pulse
    ack(5'h1F);
    pulse(5'h0A);
    cyc(1'b1, 13'h1000, 32'h100, '0);
    chk("R4 flush hi", {30'h0, flush_o, soft_rst_o}, 32'h2);
    chk_state("R4 R2 bits 8/9 read 0");
    @(negedge clk_i);
    chk("R4 flush lo", {30'h0, flush_o, soft_rst_o}, 0);

    // R5 soft reset restores mask, keeps pending
    set_mask(5'h00);
    chk_state("R5 pre");
    cyc(1'b1, 13'h1000, 32'h200, '0);
    m_mask = 5'h1F;
    chk("R4 R5 srst hi", {30'h0, flush_o, soft_rst_o}, 32'h1);
    rd(13'h1010, d); chk("R5 mask", d, exp_msk());
    chk_state("R5 pend kept");
    @(negedge clk_i);
    chk("R4 srst lo", {30'h0, flush_o, soft_rst_o}, 0);

    // R6 field over consecutive vsyncs
    for (int i = 0; i < 6; i++) begin
      pulse(5'h08);
      chk_state("R6 field");
    end

    // R7 fifo status encodings
    for (int f = 0; f < 4; f++) begin
      fifo_empty_i = f[0]; fifo_afull_i = f[1];
      m_fifo = f[0] ? 2'b01 : (f[1] ? 2'b10 : 2'b00);
      chk_state("R7 fifo");
    end

    // R11 ID registers
    for (int i = 0; i < 8; i++) begin
      logic [31:0] s, l;
      s = 32'h1 << (i * 4) ^ 32'hA5A5_0F0F;
      l = ~s + i;
      cyc(1'b1, 13'h1080, s, '0);
      cyc(1'b1, 13'h1084, l, '0);
      rd(13'h1080, d); chk("R11 sig", d, s);
      rd(13'h1084, d); chk("R11 lbl", d, l);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule